// File: doc/BRIEF.md
# Bus-Master DMA Register Port

This block sits behind a small I/O window and exposes the bus-master control registers of a dual-channel disk controller. Every channel owns an 8-byte slot in the window: the lower half of a slot carries four single-byte control registers, and the upper half carries a 32-bit pointer to the DMA descriptor table. Accesses arrive as one-cycle requests that carry an address, a size in bytes, write data and a read/write flag. Reads return a registered response one cycle later.

The control bytes are the command byte, a view onto a mode register shared by all channels, a status byte and a per-channel timing byte. A command write is forwarded to the DMA transfer engine as a one-cycle strobe. A write to the mode view updates only the two interrupt-mask bits and raises a strobe toward the interrupt logic. The status byte combines several bit types. One bit follows the engine's active signal. Two sticky flags are set by engine pulses and cleared by writing one. Two bits are plain read/write. The remaining bits always read as zero. The block holds only register state. The transfer engine and the interrupt logic are separate blocks.

Top module: `bmdma_regport`

## Requirements
- R1: After reset every command, status, timing and pointer register and the mode mask read as zero. `rsp_valid`, `cmd_wr_o` and `mode_wr_o` are low.
- R2: Channel c occupies window offsets 8*c to 8*c+7. Lanes 0 to 3 of a slot are control bytes and lanes 4 to 7 are the descriptor pointer. The registers of one channel are independent of the registers of the other.
- R3: `acc_size` gives the access size in bytes (1, 2 or 4). Any access to a control lane with a size other than 1 reads back as all ones over the access width (0x000000FF, 0x0000FFFF or 0xFFFFFFFF). Such a write changes nothing and raises no strobe.
- R4: A byte write to lane 0 (command) produces a one-cycle `cmd_wr_o` pulse in the next cycle, carrying the channel on `cmd_ch_o` and the byte on `cmd_data_o`. A read of lane 0 returns the last byte written.
- R5: A byte read of lane 1 returns the shared mode view: bits 7:6 and 3:0 come from `mode_ext_i`, and bits 5:4 are the local mask. A byte write to lane 1 from any channel changes only mask bits 5:4, and `mode_wr_o` pulses in the next cycle.
- R6: In a status write (lane 2), bits 6:5 take the written value. Status bits 7, 4 and 3 always read zero.
- R7: Status bit 0 always reflects `eng_active_i` for its channel at the sampling edge. Writes never change it.
- R8: Status bit 1 (error) and bit 2 (interrupt) are set by pulses on `eng_err_i` and `eng_irq_i` and stay set. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. A pulse in the same cycle as a clearing write wins.
- R9: Lane 3 is a read/write timing byte with a separate copy per channel.
- R10: The descriptor pointer accepts naturally aligned accesses of 1, 2 or 4 bytes. Write data is right-aligned and goes to the addressed lanes. Pointer bits 1:0 always read zero. A misaligned pointer access reads all ones and its write is ignored. `desc_ptr_o` carries every channel's pointer.
- R11: A read produces `rsp_valid` with `rsp_data` exactly one cycle after the request. The data is right-aligned and zero above the access width. A write never produces `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW (4) | Byte offset in the window |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Right-aligned read data |
| cmd_wr_o | output | 1 | Command write strobe to the DMA engine |
| cmd_ch_o | output | CW (1) | Channel of the command write |
| cmd_data_o | output | 8 | Command byte written |
| eng_active_i | input | NCH | Engine active, per channel |
| eng_err_i | input | NCH | Engine error pulse, per channel |
| eng_irq_i | input | NCH | Engine interrupt pulse, per channel |
| mode_ext_i | input | 8 | Externally held mode bits (7:6, 3:0 used) |
| mode_mask_o | output | 2 | Shared interrupt mask bits (mode bits 5:4) |
| mode_wr_o | output | 1 | Mode write strobe to the interrupt logic |
| desc_ptr_o | output | 32*NCH | Descriptor pointers, channel c at bits 32c+31:32c |

## Verification
Status writes use several patterns. An all-ones write separates the writable bits from those forced to zero. A write while the engine is active shows that bit 0 is untouched. A one-hot write shows that each sticky flag clears on its own bit. A write that coincides with an engine pulse shows which of the two wins. Pointer accesses cover byte, half-word and word sizes at different lanes, plus a misaligned case. These show lane placement, the forcing of the low bits and the rejection of misaligned accesses. Wide accesses to control lanes, together with traffic on two channels and the shared mode view, separate per-channel state from shared state and show that rejected accesses change nothing.

// File: rtl/bmdma_regport_pkg.sv
package bmdma_regport_pkg;
   localparam int SLOT_BYTES = 8;
   localparam int PTR_W      = 32;

   localparam logic [1:0] LANE_CMD  = 2'd0;
   localparam logic [1:0] LANE_MODE = 2'd1;
   localparam logic [1:0] LANE_STS  = 2'd2;
   localparam logic [1:0] LANE_TIM  = 2'd3;

   localparam int STS_ACT = 0;
   localparam int STS_ERR = 1;
   localparam int STS_IRQ = 2;
   localparam int STS_RW0 = 5;
   localparam int STS_RW1 = 6;

   localparam int MODE_MSK_LO = 4;

   function automatic logic [31:0] size_ones(input logic [2:0] sz);
      case (sz)
         3'd1:    size_ones = 32'h0000_00FF;
         3'd2:    size_ones = 32'h0000_FFFF;
         default: size_ones = 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/bmdma_acc_decode.sv
module bmdma_acc_decode
   import bmdma_regport_pkg::*;
#(
   parameter int NCH = 2,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW = CW + 3
) (
   input  logic          valid,
   input  logic [AW-1:0] addr,
   input  logic [2:0]    size,
   input  logic [31:0]   wdata,
   output logic [CW-1:0] ch,
   output logic          ctrl_ok,
   output logic          ptr_ok,
   output logic [1:0]    lane,
   output logic [3:0]    be,
   output logic [31:0]   wlane,
   output logic [31:0]   ones
);
   logic aligned;

   assign ch   = addr[AW-1:3];
   assign lane = addr[1:0];

   always_comb begin
      case (size)
         3'd1:    begin aligned = 1'b1;           be = 4'b0001 << lane; end
         3'd2:    begin aligned = ~addr[0];       be = 4'b0011 << lane; end
         3'd4:    begin aligned = (lane == 2'd0); be = 4'b1111;         end
         default: begin aligned = 1'b0;           be = 4'b0000;         end
      endcase
   end

   assign ctrl_ok = valid & ~addr[2] & (size == 3'd1);
   assign ptr_ok  = valid &  addr[2] & aligned;
   assign wlane   = wdata << {lane, 3'b000};
   assign ones    = size_ones(size);
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
   import bmdma_regport_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic             sts_we,
   input  logic             tim_we,
   input  logic [3:0]       ptr_be,
   input  logic [7:0]       wbyte,
   input  logic [31:0]      wword,
   input  logic             eng_active,
   input  logic             eng_err,
   input  logic             eng_irq,
   output logic [7:0]       cmd_q,
   output logic [7:0]       sts_q,
   output logic [7:0]       tim_q,
   output logic [PTR_W-1:0] ptr_q
);
   logic       err_r, irq_r;
   logic [1:0] rw_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         tim_q <= '0;
         rw_r  <= '0;
         err_r <= 1'b0;
         irq_r <= 1'b0;
      end else begin
         if (cmd_we) cmd_q <= wbyte;
         if (tim_we) tim_q <= wbyte;
         if (sts_we) rw_r <= {wbyte[STS_RW1], wbyte[STS_RW0]};
         if (eng_err)                      err_r <= 1'b1;
         else if (sts_we && wbyte[STS_ERR]) err_r <= 1'b0;
         if (eng_irq)                      irq_r <= 1'b1;
         else if (sts_we && wbyte[STS_IRQ]) irq_r <= 1'b0;
      end
   end

   always_comb begin
      sts_q          = '0;
      sts_q[STS_ACT] = eng_active;
      sts_q[STS_ERR] = err_r;
      sts_q[STS_IRQ] = irq_r;
      sts_q[STS_RW0] = rw_r[0];
      sts_q[STS_RW1] = rw_r[1];
   end

   for (genvar b = 0; b < 4; b++) begin : g_lane
      localparam logic [7:0] KEEP = (b == 0) ? 8'hFC : 8'hFF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ptr_q[8*b +: 8] <= '0;
         else if (ptr_be[b]) ptr_q[8*b +: 8] <= wword[8*b +: 8] & KEEP;
      end
   end

   assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err |=> sts_q[STS_ERR]);
   assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_irq |=> sts_q[STS_IRQ]);
   assert_tim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tim_we |=> $stable(tim_q));
   assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_be == 4'b0000) |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_regport.sv
module bmdma_regport
   import bmdma_regport_pkg::*;
#(
   parameter int NCH = 2,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW = CW + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [AW-1:0]      acc_addr,
   input  logic [2:0]         acc_size,
   input  logic [31:0]        acc_wdata,
   output logic               rsp_valid,
   output logic [31:0]        rsp_data,
   output logic               cmd_wr_o,
   output logic [CW-1:0]      cmd_ch_o,
   output logic [7:0]         cmd_data_o,
   input  logic [NCH-1:0]     eng_active_i,
   input  logic [NCH-1:0]     eng_err_i,
   input  logic [NCH-1:0]     eng_irq_i,
   input  logic [7:0]         mode_ext_i,
   output logic [1:0]         mode_mask_o,
   output logic               mode_wr_o,
   output logic [NCH*32-1:0]  desc_ptr_o
);
   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("bmdma_regport: NCH must be a power of two, at least 2");
   end

   logic [CW-1:0] dec_ch;
   logic          ctrl_ok, ptr_ok;
   logic [1:0]    lane;
   logic [3:0]    be;
   logic [31:0]   wlane, ones;

   bmdma_acc_decode #(.NCH(NCH)) u_dec (
      .valid(acc_valid), .addr(acc_addr), .size(acc_size), .wdata(acc_wdata),
      .ch(dec_ch), .ctrl_ok(ctrl_ok), .ptr_ok(ptr_ok), .lane(lane), .be(be),
      .wlane(wlane), .ones(ones)
   );

   logic acc_wr, acc_rd, mode_we;
   assign acc_wr  = acc_valid &  acc_write;
   assign acc_rd  = acc_valid & ~acc_write;
   assign mode_we = acc_wr & ctrl_ok & (lane == LANE_MODE);

   logic [7:0]     cmd_a [NCH];
   logic [7:0]     sts_a [NCH];
   logic [7:0]     tim_a [NCH];
   logic [31:0]    ptr_a [NCH];
   logic [NCH-1:0] cmd_we;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel       = (dec_ch == CW'(c));
      assign cmd_we[c] = acc_wr & ctrl_ok & sel & (lane == LANE_CMD);

      bmdma_chan_regs u_regs (
         .clk(clk), .rst_n(rst_n),
         .cmd_we(cmd_we[c]),
         .sts_we(acc_wr & ctrl_ok & sel & (lane == LANE_STS)),
         .tim_we(acc_wr & ctrl_ok & sel & (lane == LANE_TIM)),
         .ptr_be((acc_wr & ptr_ok & sel) ? be : 4'b0000),
         .wbyte(acc_wdata[7:0]), .wword(wlane),
         .eng_active(eng_active_i[c]), .eng_err(eng_err_i[c]), .eng_irq(eng_irq_i[c]),
         .cmd_q(cmd_a[c]), .sts_q(sts_a[c]), .tim_q(tim_a[c]), .ptr_q(ptr_a[c])
      );
      assign desc_ptr_o[32*c +: 32] = ptr_a[c];
   end

   logic [7:0]  mode_view;
   logic [31:0] rd_word;

   always_comb begin
      mode_view = mode_ext_i;
      mode_view[MODE_MSK_LO +: 2] = mode_mask_o;
   end

   always_comb begin
      rd_word = ones;
      if (ctrl_ok) begin
         case (lane)
            LANE_CMD:  rd_word = {24'd0, cmd_a[dec_ch]};
            LANE_MODE: rd_word = {24'd0, mode_view};
            LANE_STS:  rd_word = {24'd0, sts_a[dec_ch]};
            default:   rd_word = {24'd0, tim_a[dec_ch]};
         endcase
      end else if (ptr_ok) begin
         rd_word = (ptr_a[dec_ch] >> {lane, 3'b000}) & ones;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         cmd_wr_o    <= 1'b0;
         cmd_ch_o    <= '0;
         cmd_data_o  <= '0;
         mode_mask_o <= '0;
         mode_wr_o   <= 1'b0;
      end else begin
         rsp_valid <= acc_rd;
         rsp_data  <= acc_rd ? rd_word : 32'd0;
         cmd_wr_o  <= |cmd_we;
         if (|cmd_we) begin
            cmd_ch_o   <= dec_ch;
            cmd_data_o <= acc_wdata[7:0];
         end
         mode_wr_o <= mode_we;
         if (mode_we) mode_mask_o <= acc_wdata[MODE_MSK_LO +: 2];
      end
   end

   assert_rsp_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(acc_valid && !acc_write));
   assert_cmd_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr_o |-> $past(acc_valid && acc_write && acc_size == 3'd1 &&
                         acc_addr[2:0] == 3'd0));
   assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_we |=> $stable(mode_mask_o));
   assert_wide_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_size != 3'd1 && !acc_addr[2])
         |=> (!cmd_wr_o && !mode_wr_o));
endmodule

// File: tb/bmdma_regport_tb.sv
module bmdma_regport_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [3:0]  acc_addr = '0;
   logic [2:0]  acc_size = 3'd1;
   logic [31:0] acc_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        cmd_wr_o;
   logic [0:0]  cmd_ch_o;
   logic [7:0]  cmd_data_o;
   logic [1:0]  eng_active_i = '0, eng_err_i = '0, eng_irq_i = '0;
   logic [7:0]  mode_ext_i = '0;
   logic [1:0]  mode_mask_o;
   logic        mode_wr_o;
   logic [63:0] desc_ptr_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   bmdma_regport u_dut (.*);

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard on every read response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) check("R11 unexpected response", 32'd1, 32'd0);
         else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
   end

   task automatic acc(bit w, logic [3:0] a, logic [2:0] s, logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [2:0] s, logic [31:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      acc(1'b0, a, s, 32'd0);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check("watchdog expired", 32'd1, 32'd0);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R1 cmd_wr_o", {31'd0, cmd_wr_o}, 32'd0);
      check("R1 mode_wr_o", {31'd0, mode_wr_o}, 32'd0);
      check("R1 mask", {30'd0, mode_mask_o}, 32'd0);
      check("R1 ptr lo", desc_ptr_o[31:0], 32'd0);
      check("R1 ptr hi", desc_ptr_o[63:32], 32'd0);
      rd(4'd0, 3'd1, 32'h00, "R1 cmd0");
      rd(4'd1, 3'd1, 32'h00, "R1 mode");
      rd(4'd10, 3'd1, 32'h00, "R1 sts1");
      rd(4'd3, 3'd1, 32'h00, "R1 tim0");
      rd(4'd12, 3'd4, 32'h0, "R1 ptr1");

      // R4 command forwarding
      acc(1'b1, 4'd0, 3'd1, 32'h09);
      check("R4 cmd_wr_o pulse", {31'd0, cmd_wr_o}, 32'd1);
      check("R4 cmd_ch_o", {31'd0, cmd_ch_o}, 32'd0);
      check("R4 cmd_data_o", {24'd0, cmd_data_o}, 32'h09);
      check("R11 no rsp on write", {31'd0, rsp_valid}, 32'd0);
      acc(1'b1, 4'd8, 3'd1, 32'h01);
      check("R4 cmd_ch_o ch1", {31'd0, cmd_ch_o}, 32'd1);
      rd(4'd0, 3'd1, 32'h09, "R4 cmd0 readback");
      check("R4 pulse one cycle", {31'd0, cmd_wr_o}, 32'd0);
      rd(4'd8, 3'd1, 32'h01, "R2 cmd1 independent");

      // R5 shared mode view
      mode_ext_i = 8'hCF;
      acc(1'b1, 4'd9, 3'd1, 32'hFF);
      check("R5 mode strobe", {31'd0, mode_wr_o}, 32'd1);
      check("R5 mask", {30'd0, mode_mask_o}, 32'd3);
      rd(4'd1, 3'd1, 32'hFF, "R5 view from ch0");
      mode_ext_i = 8'h0C;
      rd(4'd9, 3'd1, 32'h3C, "R5 ext bits pass");
      acc(1'b1, 4'd1, 3'd1, 32'h10);
      rd(4'd1, 3'd1, 32'h1C, "R5 partial mask");

      // R6/R7 status
      acc(1'b1, 4'd2, 3'd1, 32'hFF);
      rd(4'd2, 3'd1, 32'h60, "R6 rw bits and zeros");
      eng_active_i[0] = 1'b1;
      rd(4'd2, 3'd1, 32'h61, "R7 active shown");
      acc(1'b1, 4'd2, 3'd1, 32'h00);
      rd(4'd2, 3'd1, 32'h01, "R7 active kept by write");
      rd(4'd10, 3'd1, 32'h00, "R2 sts1 untouched");

      // R8 sticky flags
      @(negedge clk); eng_err_i[0] = 1'b1; eng_irq_i[1] = 1'b1;
      @(negedge clk); eng_err_i = '0; eng_irq_i = '0;
      rd(4'd2, 3'd1, 32'h03, "R8 err set");
      rd(4'd10, 3'd1, 32'h04, "R8 irq set");
      acc(1'b1, 4'd2, 3'd1, 32'h04);
      rd(4'd2, 3'd1, 32'h03, "R8 err kept on other clear");
      acc(1'b1, 4'd2, 3'd1, 32'h02);
      rd(4'd2, 3'd1, 32'h01, "R8 err cleared");
      eng_irq_i[1] = 1'b1;
      acc(1'b1, 4'd10, 3'd1, 32'h04);
      eng_irq_i[1] = 1'b0;
      rd(4'd10, 3'd1, 32'h04, "R8 set wins over clear");
      acc(1'b1, 4'd10, 3'd1, 32'h04);
      rd(4'd10, 3'd1, 32'h00, "R8 irq cleared");

      // R9 timing
      acc(1'b1, 4'd3, 3'd1, 32'hA5);
      acc(1'b1, 4'd11, 3'd1, 32'h3C);
      rd(4'd3, 3'd1, 32'hA5, "R9 tim0");
      rd(4'd11, 3'd1, 32'h3C, "R9 tim1");

      // R3 wide control accesses
      rd(4'd0, 3'd2, 32'h0000FFFF, "R3 half read ones");
      rd(4'd0, 3'd4, 32'hFFFFFFFF, "R3 word read ones");
      acc(1'b1, 4'd0, 3'd4, 32'h11223344);
      check("R3 no cmd strobe", {31'd0, cmd_wr_o}, 32'd0);
      acc(1'b1, 4'd2, 3'd2, 32'h0000FFFF);
      check("R3 no mode strobe", {31'd0, mode_wr_o}, 32'd0);
      rd(4'd0, 3'd1, 32'h09, "R3 cmd unchanged");
      rd(4'd3, 3'd1, 32'hA5, "R3 tim unchanged");
      rd(4'd1, 3'd1, 32'h1C, "R3 mode unchanged");

      // R10 descriptor pointer
      acc(1'b1, 4'd12, 3'd4, 32'h12345677);
      rd(4'd12, 3'd4, 32'h12345674, "R10 word, low bits zero");
      check("R10 desc_ptr_o ch1", desc_ptr_o[63:32], 32'h12345674);
      acc(1'b1, 4'd13, 3'd1, 32'hAB);
      acc(1'b1, 4'd14, 3'd2, 32'hBEEF);
      rd(4'd12, 3'd4, 32'hBEEFAB74, "R10 byte and half lanes");
      rd(4'd14, 3'd2, 32'h0000BEEF, "R10 half read");
      rd(4'd13, 3'd1, 32'h000000AB, "R10 byte read");
      rd(4'd13, 3'd2, 32'h0000FFFF, "R10 misaligned read");
      acc(1'b1, 4'd13, 3'd4, 32'h0);
      rd(4'd12, 3'd4, 32'hBEEFAB74, "R10 misaligned write ignored");
      check("R2 ptr ch0 untouched", desc_ptr_o[31:0], 32'd0);

      repeat (3) @(negedge clk);
      check("R11 all responses seen", exp_q.size(), 32'd0);
      finish_up();
   end
endmodule